// File: doc/BRIEF.md
# Buffered Line Error Counter Bank

This block accumulates error events reported by a framed serial line receiver. It has four 16-bit saturating counters, one each for line code violations, framing bit errors, CRC-6 errors and errored blocks. A fifth 8-bit register is split into two narrower saturating counts: one for multiframes received while alignment is lost, and one for changes of frame alignment. Each event arrives as a single-cycle pulse on its own bit of an event vector. Frame alignment and event detection happen upstream of this block.

Software never sees the live counters. Each counter has a shadow register, and software reads only the shadow. All shadows are loaded at the same time, and in the same cycle every counter restarts. This snapshot happens in one of two modes. In the periodic mode, each pulse of a one-second tick takes a snapshot. In the on-demand mode, a write strobe from the register interface starts the snapshot, and a busy flag reports when it has finished. No event is lost at a snapshot: an event that arrives in the snapshot cycle becomes the first count of the new period.

Top module: `line_err_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters and all shadow registers are zero and `dem_busy` is low.
- R2: Each event pulse adds one to its own counter. The bits of `evt_pulse` map as follows: bit 0 is code violations, bit 1 is framing bit errors, bit 2 is CRC-6 errors, bit 3 is errored blocks, bit 4 is multiframes received out of alignment, and bit 5 is changes of frame alignment.
- R3: A 16-bit counter stops at 65535 and holds that value until the next snapshot.
- R4: In `buf_align`, bits [5:0] hold the out-of-alignment multiframe count and bits [7:6] hold the alignment-change count. Each field saturates on its own, at 63 and at 3.
- R5: When `mode_demand` is 0, a `sec_tick` pulse copies every counter into its shadow at that clock edge, and every counter restarts.
- R6: An event that arrives in the same cycle as a snapshot is not lost. Its counter restarts at 1 instead of 0.
- R7: When `mode_demand` is 1, a `dem_wr` pulse raises `dem_busy` at the next edge. On the edge after that, all shadows load together, the counters restart and `dem_busy` falls.
- R8: When `mode_demand` is 1, `sec_tick` is ignored. When `mode_demand` is 0, `dem_wr` is ignored. An ignored pulse leaves the shadows and `dem_busy` unchanged.
- R9: Between snapshots, the shadow registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 6 | Single-cycle error event pulses, one bit per counter |
| sec_tick | input | 1 | One-second tick pulse |
| mode_demand | input | 1 | 0 = snapshot on tick, 1 = snapshot on demand write |
| dem_wr | input | 1 | Demand write strobe from the register interface |
| buf_cv | output | 16 | Shadow of the code violation count |
| buf_fbe | output | 16 | Shadow of the framing bit error count |
| buf_crc | output | 16 | Shadow of the CRC-6 error count |
| buf_ebl | output | 16 | Shadow of the errored block count |
| buf_align | output | 8 | Shadow of the split alignment register |
| dem_busy | output | 1 | High while a demand snapshot is pending |

## Verification
Each event bit is first pulsed a different number of times, so that a swapped or shared counter shows up as a wrong value in some shadow. An event landing in the same cycle as a tick separates a counter that restarts at 1 from one that drops the event. Long runs of back-to-back events drive every field to its limit, which shows whether it saturates or wraps, and whether the two split fields are kept apart. Demand writes and ticks are then sent in both modes, in directed patterns and in seeded random mixes, to confirm which stimulus is ignored in which mode and on which edge the busy flag falls.

// File: rtl/lec_pkg.sv
// Shared constants for the line error counter bank.
// Assumes that the event vector order is fixed by the upstream detector.
package lec_pkg;
    localparam int NUM_EV    = 6;
    localparam int NUM_WIDE  = 4;
    localparam int IDX_CV    = 0;
    localparam int IDX_FBE   = 1;
    localparam int IDX_CRC   = 2;
    localparam int IDX_EBL   = 3;
    localparam int IDX_MFOA  = 4;
    localparam int IDX_COFA  = 5;
endpackage

// File: rtl/lec_sat_cnt.sv
// Saturating event counter with a clear that still counts an event arriving
// in the same cycle. Assumes inc is at most one event per cycle.
module lec_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_VAL = '1;

    // Count, hold at the maximum, or restart at 0 or 1 on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? W'(1) : '0;
        end else if (inc && (cnt != MAX_VAL)) begin
            cnt <= cnt + W'(1);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX_VAL && !clr) |=> (cnt == MAX_VAL));
    p_restart_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt == W'(1)));
    p_restart_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt == '0));
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != MAX_VAL) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/lec_shadow.sv
// Shadow register that software reads. It captures its counter on load and
// otherwise holds its value.
module lec_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the live count when a snapshot happens.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_buf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));
    p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/lec_snap_ctrl.sv
// Chooses the snapshot source. In tick mode the tick fires the snapshot at
// once. In demand mode the write sets busy, and the snapshot fires on the
// following edge, which also clears busy. Assumes single-cycle strobes.
module lec_snap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic mode_demand,
    input  logic dem_wr,
    output logic snap,
    output logic busy
);
    // Demand handshake: set on an accepted write, drop after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   busy <= 1'b0;
        else if (busy)                busy <= 1'b0;
        else if (mode_demand && dem_wr) busy <= 1'b1;
    end

    // Snapshot strobe shared by every counter and shadow.
    always_comb begin
        snap = busy || (!mode_demand && sec_tick);
    end

    p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_demand && dem_wr && !busy) |=> busy);
    p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_demand && !busy) |=> !busy);
endmodule

// File: rtl/line_err_bank.sv
// Top level of the error counter bank: four wide saturating counters plus a
// split alignment register, each paired with a shadow register. All of them
// share one snapshot strobe. Assumes event pulses are already synchronous.
module line_err_bank #(
    parameter int CNT_W = 16,
    parameter int MF_W  = 6,
    parameter int CF_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [lec_pkg::NUM_EV-1:0] evt_pulse,
    input  logic                       sec_tick,
    input  logic                       mode_demand,
    input  logic                       dem_wr,
    output logic [CNT_W-1:0]           buf_cv,
    output logic [CNT_W-1:0]           buf_fbe,
    output logic [CNT_W-1:0]           buf_crc,
    output logic [CNT_W-1:0]           buf_ebl,
    output logic [MF_W+CF_W-1:0]       buf_align,
    output logic                       dem_busy
);
    localparam int SPLIT_W = MF_W + CF_W;
    localparam int NW      = lec_pkg::NUM_WIDE;

    logic               snap;
    logic [CNT_W-1:0]   wide_cnt [NW];
    logic [CNT_W-1:0]   wide_buf [NW];
    logic [MF_W-1:0]    mf_cnt;
    logic [CF_W-1:0]    cf_cnt;

    lec_snap_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .mode_demand (mode_demand),
        .dem_wr      (dem_wr),
        .snap        (snap),
        .busy        (dem_busy)
    );

    for (genvar g = 0; g < NW; g++) begin : g_wide
        lec_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_pulse[g]),
            .clr   (snap),
            .cnt   (wide_cnt[g])
        );
        lec_shadow #(.W(CNT_W)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (snap),
            .d     (wide_cnt[g]),
            .q     (wide_buf[g])
        );
    end

    lec_sat_cnt #(.W(MF_W)) u_mf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt_pulse[lec_pkg::IDX_MFOA]),
        .clr   (snap),
        .cnt   (mf_cnt)
    );

    lec_sat_cnt #(.W(CF_W)) u_cf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt_pulse[lec_pkg::IDX_COFA]),
        .clr   (snap),
        .cnt   (cf_cnt)
    );

    lec_shadow #(.W(SPLIT_W)) u_align_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (snap),
        .d     ({cf_cnt, mf_cnt}),
        .q     (buf_align)
    );

    // Route the wide shadows to their named outputs.
    always_comb begin
        buf_cv  = wide_buf[lec_pkg::IDX_CV];
        buf_fbe = wide_buf[lec_pkg::IDX_FBE];
        buf_crc = wide_buf[lec_pkg::IDX_CRC];
        buf_ebl = wide_buf[lec_pkg::IDX_EBL];
    end

    p_shadows_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (buf_align == {$past(cf_cnt), $past(mf_cnt)}));
endmodule

// File: tb/line_err_bank_tb.sv
// Self-checking bench: a reference model in bench functions, directed corner
// cases, then seeded random traffic in both modes.
module line_err_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_pulse = '0;
    logic        sec_tick = 1'b0;
    logic        mode_demand = 1'b0;
    logic        dem_wr = 1'b0;
    logic [15:0] buf_cv, buf_fbe, buf_crc, buf_ebl;
    logic [7:0]  buf_align;
    logic        dem_busy;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    string       cur_req = "R1";
    bit          m_mode = 1'b0;
    bit          m_busy = 1'b0;
    int unsigned mc [4];
    int unsigned mb [4];
    int unsigned m_mf, m_cf, mb_al;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_err_bank u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sec_tick(sec_tick),
        .mode_demand(mode_demand), .dem_wr(dem_wr), .buf_cv(buf_cv),
        .buf_fbe(buf_fbe), .buf_crc(buf_crc), .buf_ebl(buf_ebl),
        .buf_align(buf_align), .dem_busy(dem_busy)
    );

    function automatic int unsigned bump(int unsigned v, bit inc, int unsigned mx);
        return (inc && v < mx) ? v + 1 : v;
    endfunction

    task automatic chk(string req, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "buf_cv", buf_cv, mb[0]);
        chk(cur_req, "buf_fbe", buf_fbe, mb[1]);
        chk(cur_req, "buf_crc", buf_crc, mb[2]);
        chk(cur_req, "buf_ebl", buf_ebl, mb[3]);
        chk(cur_req, "buf_align", buf_align, mb_al);
        chk(cur_req, "dem_busy", dem_busy, m_busy);
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, compare a quarter period later.
    task automatic step(logic [5:0] ev, logic tk, logic wr);
        bit s, nb;
        @(negedge clk);
        evt_pulse = ev; sec_tick = tk; dem_wr = wr; mode_demand = m_mode;
        @(posedge clk);
        s  = m_busy || (!m_mode && tk);
        nb = !m_busy && m_mode && wr;
        for (int i = 0; i < 4; i++) begin
            if (s) begin mb[i] = mc[i]; mc[i] = ev[i] ? 1 : 0; end
            else mc[i] = bump(mc[i], ev[i], 65535);
        end
        if (s) begin
            mb_al = m_cf * 64 + m_mf;
            m_mf = ev[4] ? 1 : 0;
            m_cf = ev[5] ? 1 : 0;
        end else begin
            m_mf = bump(m_mf, ev[4], 63);
            m_cf = bump(m_cf, ev[5], 3);
        end
        m_busy = nb;
        #(CLK_PERIOD/4);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) begin mc[i] = 0; mb[i] = 0; end
        m_mf = 0; m_cf = 0; mb_al = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R1: reset state
        cur_req = "R1";
        compare_all();
        step(6'h00, 1'b1, 1'b0);
        chk("R1", "buf_cv after empty tick", buf_cv, 0);

        // R2, R4: distinct pulse counts per bit, then a tick (R5)
        cur_req = "R2";
        for (int b = 0; b < 6; b++)
            for (int k = 0; k <= b; k++) step(6'(1 << b), 1'b0, 1'b0);
        cur_req = "R5";
        step(6'h00, 1'b1, 1'b0);
        chk("R2", "buf_cv", buf_cv, 1);
        chk("R2", "buf_fbe", buf_fbe, 2);
        chk("R2", "buf_crc", buf_crc, 3);
        chk("R2", "buf_ebl", buf_ebl, 4);
        chk("R4", "buf_align split", buf_align, 3 * 64 + 5);

        // R6: events in the snapshot cycle start the new period at 1
        cur_req = "R6";
        step(6'h3f, 1'b0, 1'b0);
        step(6'h3f, 1'b1, 1'b0);
        step(6'h00, 1'b1, 1'b0);
        chk("R6", "buf_crc restart", buf_crc, 1);
        chk("R6", "buf_align restart", buf_align, 65);

        // R8: demand write ignored in tick mode
        cur_req = "R8";
        step(6'h01, 1'b0, 1'b1);
        chk("R8", "busy in tick mode", dem_busy, 0);

        // R7: demand handshake
        m_mode = 1'b1;
        cur_req = "R7";
        step(6'h01, 1'b0, 1'b0);
        step(6'h00, 1'b0, 1'b1);
        chk("R7", "busy raised", dem_busy, 1);
        chk("R7", "buffer not yet loaded", buf_cv, 1);
        step(6'h00, 1'b0, 1'b0);
        chk("R7", "busy dropped", dem_busy, 0);
        chk("R7", "buffer loaded", buf_cv, 2);

        // R8: tick ignored in demand mode
        cur_req = "R8";
        step(6'h3f, 1'b1, 1'b0);
        chk("R8", "tick ignored", buf_cv, 2);

        // R3, R4: saturation
        m_mode = 1'b0;
        step(6'h00, 1'b1, 1'b0);
        cur_req = "R3";
        for (int k = 0; k < 66000; k++) step(6'h3f, 1'b0, 1'b0);
        step(6'h00, 1'b1, 1'b0);
        chk("R3", "buf_ebl saturated", buf_ebl, 65535);
        chk("R4", "buf_align saturated", buf_align, 255);

        // R9: random traffic in both modes
        cur_req = "R9";
        for (int seg = 0; seg < 40; seg++) begin
            step(6'h00, 1'b0, 1'b0);
            step(6'h00, 1'b0, 1'b0);
            m_mode = $urandom_range(0, 1) == 1;
            for (int k = 0; k < 100; k++)
                step(6'($urandom), ($urandom_range(0, 19) == 0),
                     ($urandom_range(0, 14) == 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule